// File: doc/BRIEF.md
# Clock failure switchover monitor

The block watches two oscillators: the primary clock, which also clocks the system, and a slow watchdog oscillator. Each oscillator is checked from the other one's domain. To check the primary clock, the watchdog domain sends a toggling token to the primary domain and waits for it to come back. If no round trip finishes within a set number of watchdog cycles, the primary clock is declared dead. The primary domain checks the watchdog clock the same way, counting primary cycles, with a limit of 8000 by default.

A primary failure is detected only while its enable is set. It raises an exception pulse in the watchdog domain and sets a sticky override that moves the system clock source to the watchdog oscillator. The override is not set when the watchdog oscillator is already the chosen primary source. A watchdog failure always sets its sticky flag. It raises an exception only when its own enable is set, and it never moves the clock source. It also turns primary detection off until the next reset. The clock multiplexer itself lies outside the block: the block provides only its select line.

Top module: `clk_fail_switch`

## Requirements
- R1: While rst_ni is low and just after it rises, sel_wdt_o, pri_fail_o, pri_exc_o, wdt_fail_o and wdt_exc_o are all 0.
- R2: While both clocks run, neither pri_fail_o nor wdt_fail_o is set. This holds for PRI_LIMIT >= 8, with the watchdog period no more than 8 primary periods and no more than WDT_LIMIT/10 primary periods.
- R3: If pri_fail_en_i is 1 and the primary clock stops, pri_fail_o becomes 1. This happens no earlier than PRI_LIMIT-4 and no later than PRI_LIMIT+4 watchdog cycles after the stop.
- R4: pri_exc_o is high for exactly one watchdog cycle, on the same edge where pri_fail_o rises, and only once per reset.
- R5: sel_wdt_o rises on the same watchdog edge as pri_fail_o when wdt_is_pri_i is 0. It stays 0 when wdt_is_pri_i is 1.
- R6: With pri_fail_en_i at 0, a stopped primary clock leaves pri_fail_o, pri_exc_o and sel_wdt_o at 0.
- R7: If the watchdog clock stops while the primary clock runs, wdt_fail_o becomes 1. This happens no earlier than WDT_LIMIT-40 and no later than WDT_LIMIT+40 primary cycles after the stop.
- R8: When wdt_fail_o rises, wdt_exc_o pulses for one primary cycle only if wdt_fail_en_i is 1. A watchdog failure never sets sel_wdt_o.
- R9: Once wdt_fail_o is set, a later primary stop sets neither pri_fail_o nor sel_wdt_o, even if the watchdog clock has recovered.
- R10: pri_fail_o, sel_wdt_o and wdt_fail_o are sticky: once set, they stay 1 until reset, even if the failed clock restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk_i | input | 1 | Primary (system) clock |
| wdt_clk_i | input | 1 | Slow watchdog oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pri_fail_en_i | input | 1 | Enables primary failure detection |
| wdt_fail_en_i | input | 1 | Enables the watchdog failure exception |
| wdt_is_pri_i | input | 1 | Watchdog oscillator is the selected primary source |
| sel_wdt_o | output | 1 | Sticky override forcing the clock source to the watchdog oscillator (watchdog domain) |
| pri_fail_o | output | 1 | Sticky primary failure flag (watchdog domain) |
| pri_exc_o | output | 1 | One-cycle primary failure exception (watchdog domain) |
| wdt_fail_o | output | 1 | Sticky watchdog failure flag (primary domain) |
| wdt_exc_o | output | 1 | One-cycle watchdog failure exception (primary domain) |

## Verification
The bench stops each clock in turn and checks where each flag sets against a window built from the limits and the synchroniser round trip. A design that trips too early fails the window check, and one that never trips also fails it. A design that leaves the failure count unblocked shows up in two checks. The first is a watchdog failure followed by a watchdog restart and a primary stop, which must stay silent. The second is the case where the watchdog oscillator is the primary source, in which the switchover must not happen. Exception pulses are counted per reset, so a repeated or ungated exception changes the count. After the primary clock restarts, a flag that clears shows up as a broken sticky bit.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int unsigned SYNC_MIN = 2;

  function automatic int unsigned cnt_bits(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync
  import cfm_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned DEPTH = (STAGES < SYNC_MIN) ? SYNC_MIN : STAGES;

  logic [DEPTH-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[DEPTH-2:0], d_i};
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/cfm_probe.sv
// Token round-trip liveness probe: token goes out, echo returns via a sync chain.
module cfm_probe
  import cfm_pkg::*;
#(
  parameter int unsigned LIMIT  = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic echo_i,
  output logic token_o,
  output logic trip_o
);
  localparam int unsigned CW = cnt_bits(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          token_q;
  logic          echo_s;
  logic          alive;
  logic [CW-1:0] cnt_q;

  cfm_sync #(.STAGES(STAGES), .WIDTH(1)) u_echo_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (echo_i),
    .q_o   (echo_s)
  );

  assign alive = (echo_s == token_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      token_q <= 1'b0;
      cnt_q   <= '0;
    end else if (alive) begin
      token_q <= ~token_q;
      cnt_q   <= '0;
    end else if (!en_i || cnt_q == LAST) begin
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign token_o = token_q;
  assign trip_o  = en_i & ~alive & (cnt_q == LAST);
endmodule

// File: rtl/cfm_fail_latch.sv
module cfm_fail_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic exc_en_i,
  output logic flag_o,
  output logic exc_o
);
  logic flag_q;
  logic exc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      flag_q <= flag_q | trip_i;
      exc_q  <= trip_i & ~flag_q & exc_en_i;
    end
  end

  assign flag_o = flag_q;
  assign exc_o  = exc_q;
endmodule

// File: rtl/clk_fail_switch.sv
module clk_fail_switch
  import cfm_pkg::*;
#(
  parameter int unsigned PRI_LIMIT   = 10,
  parameter int unsigned WDT_LIMIT   = 8000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic pri_clk_i,
  input  logic wdt_clk_i,
  input  logic rst_ni,
  input  logic pri_fail_en_i,
  input  logic wdt_fail_en_i,
  input  logic wdt_is_pri_i,
  output logic sel_wdt_o,
  output logic pri_fail_o,
  output logic pri_exc_o,
  output logic wdt_fail_o,
  output logic wdt_exc_o
);
  // ---------------- watchdog domain: primary liveness ----------------
  logic [2:0] wctl_s;
  logic       pri_en_s;
  logic       wdt_is_pri_s;
  logic       wdt_fail_w;
  logic       pri_det_en;
  logic       pri_tok;
  logic       pri_echo;
  logic       pri_trip;
  logic       sel_q;

  cfm_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_wctl_sync (
    .clk_i (wdt_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pri_fail_en_i, wdt_is_pri_i, wdt_fail_o}),
    .q_o   (wctl_s)
  );

  assign {pri_en_s, wdt_is_pri_s, wdt_fail_w} = wctl_s;
  // watchdog failure permanently blocks primary detection
  assign pri_det_en = pri_en_s & ~wdt_fail_w;

  cfm_probe #(.LIMIT(PRI_LIMIT), .STAGES(SYNC_STAGES)) u_pri_probe (
    .clk_i  (wdt_clk_i),
    .rst_ni (rst_ni),
    .en_i   (pri_det_en),
    .echo_i (pri_echo),
    .token_o(pri_tok),
    .trip_o (pri_trip)
  );

  cfm_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_pri_echo (
    .clk_i (pri_clk_i),
    .rst_ni(rst_ni),
    .d_i   (pri_tok),
    .q_o   (pri_echo)
  );

  cfm_fail_latch u_pri_latch (
    .clk_i   (wdt_clk_i),
    .rst_ni  (rst_ni),
    .trip_i  (pri_trip),
    .exc_en_i(1'b1),
    .flag_o  (pri_fail_o),
    .exc_o   (pri_exc_o)
  );

  always_ff @(posedge wdt_clk_i or negedge rst_ni) begin
    if (!rst_ni)                        sel_q <= 1'b0;
    else if (pri_trip && !wdt_is_pri_s) sel_q <= 1'b1;
  end

  assign sel_wdt_o = sel_q;

  // ---------------- primary domain: watchdog liveness ----------------
  logic wdt_en_s;
  logic wdt_tok;
  logic wdt_echo;
  logic wdt_trip;

  cfm_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_pctl_sync (
    .clk_i (pri_clk_i),
    .rst_ni(rst_ni),
    .d_i   (wdt_fail_en_i),
    .q_o   (wdt_en_s)
  );

  cfm_probe #(.LIMIT(WDT_LIMIT), .STAGES(SYNC_STAGES)) u_wdt_probe (
    .clk_i  (pri_clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .echo_i (wdt_echo),
    .token_o(wdt_tok),
    .trip_o (wdt_trip)
  );

  cfm_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_wdt_echo (
    .clk_i (wdt_clk_i),
    .rst_ni(rst_ni),
    .d_i   (wdt_tok),
    .q_o   (wdt_echo)
  );

  cfm_fail_latch u_wdt_latch (
    .clk_i   (pri_clk_i),
    .rst_ni  (rst_ni),
    .trip_i  (wdt_trip),
    .exc_en_i(wdt_en_s),
    .flag_o  (wdt_fail_o),
    .exc_o   (wdt_exc_o)
  );
endmodule

// File: rtl/cfm_chk.sv
module cfm_chk (
  input logic pri_clk_i,
  input logic wdt_clk_i,
  input logic rst_ni,
  input logic sel_wdt_o,
  input logic pri_fail_o,
  input logic pri_exc_o,
  input logic wdt_fail_o,
  input logic wdt_exc_o,
  input logic wdt_fail_seen,
  input logic wdt_exc_en
);
  // R4
  pri_exc_single_chk: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    pri_exc_o |=> !pri_exc_o);
  // R4
  pri_exc_on_set_chk: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    pri_exc_o |-> (pri_fail_o && !$past(pri_fail_o)));
  // R5
  sel_needs_fail_chk: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    sel_wdt_o |-> pri_fail_o);
  // R10
  pri_fail_sticky_chk: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    pri_fail_o |=> pri_fail_o);
  // R10
  sel_sticky_chk: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    sel_wdt_o |=> sel_wdt_o);
  // R9
  pri_blocked_chk: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    (wdt_fail_seen && !pri_fail_o) |=> !pri_fail_o);
  // R10
  wdt_fail_sticky_chk: assert property (@(posedge pri_clk_i) disable iff (!rst_ni)
    wdt_fail_o |=> wdt_fail_o);
  // R8
  wdt_exc_gated_chk: assert property (@(posedge pri_clk_i) disable iff (!rst_ni)
    wdt_exc_o |-> (wdt_exc_en && wdt_fail_o && !$past(wdt_fail_o)));
  // R8
  wdt_exc_single_chk: assert property (@(posedge pri_clk_i) disable iff (!rst_ni)
    wdt_exc_o |=> !wdt_exc_o);
endmodule

bind clk_fail_switch cfm_chk u_cfm_chk (
  .pri_clk_i    (pri_clk_i),
  .wdt_clk_i    (wdt_clk_i),
  .rst_ni       (rst_ni),
  .sel_wdt_o    (sel_wdt_o),
  .pri_fail_o   (pri_fail_o),
  .pri_exc_o    (pri_exc_o),
  .wdt_fail_o   (wdt_fail_o),
  .wdt_exc_o    (wdt_exc_o),
  .wdt_fail_seen(wdt_fail_w),
  .wdt_exc_en   (wdt_en_s)
);

// File: tb/tb_clk_fail_switch.sv
`timescale 1ns/1ps
module tb_clk_fail_switch;
  localparam int PL = 16;    // primary limit, watchdog cycles
  localparam int WL = 200;   // watchdog limit, primary cycles
  localparam int WR = 7;     // watchdog period in primary periods

  logic clk = 1'b0;
  logic wdt_clk = 1'b0;
  logic pri_run = 1'b1;
  logic wdt_run = 1'b1;
  logic rst_n = 1'b0;
  logic pri_en = 1'b0, wdt_en = 1'b0, is_pri = 1'b0;
  logic pri_clk;
  logic sel_wdt, pri_fail, pri_exc, wdt_fail, wdt_exc;

  assign pri_clk = clk & pri_run;

  clk_fail_switch #(.PRI_LIMIT(PL), .WDT_LIMIT(WL), .SYNC_STAGES(2)) dut (
    .pri_clk_i    (pri_clk),
    .wdt_clk_i    (wdt_clk),
    .rst_ni       (rst_n),
    .pri_fail_en_i(pri_en),
    .wdt_fail_en_i(wdt_en),
    .wdt_is_pri_i (is_pri),
    .sel_wdt_o    (sel_wdt),
    .pri_fail_o   (pri_fail),
    .pri_exc_o    (pri_exc),
    .wdt_fail_o   (wdt_fail),
    .wdt_exc_o    (wdt_exc)
  );

  always #5 clk = ~clk;
  initial begin
    #3;
    forever begin
      #35;
      if (wdt_run) wdt_clk = ~wdt_clk;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit    model_on = 0;
  int    pri_stop = 0, wdt_stop = 0;
  bit    pri_maybe, pri_must, wdt_maybe, wdt_must;
  int    pri_pulses, wdt_pulses;
  logic  prev_pf, prev_sel, prev_wf, prev_pe, prev_we;
  string scen_req = "R2";

  always @(negedge clk) begin
    if (model_on) begin
      pri_stop = pri_run ? 0 : pri_stop + 1;
      if (wdt_run) wdt_stop = 0;
      else if (pri_run) wdt_stop = wdt_stop + 1;
      if (wdt_stop >= WL - 40) wdt_maybe = 1;
      if (wdt_stop >= WL + 40) wdt_must = 1;
      if (pri_en && !wdt_maybe && pri_stop >= (PL - 4) * WR) pri_maybe = 1;
      if (pri_en && !wdt_maybe && pri_stop >= (PL + 4) * WR) pri_must = 1;

      if (!pri_maybe) chk(pri_fail == 1'b0, scen_req, "pri_fail early", pri_fail, 0);
      if (pri_must)   chk(pri_fail == 1'b1, "R3", "pri_fail late", pri_fail, 1);
      if (is_pri) chk(sel_wdt == 1'b0, "R5", "sel with wdt as primary", sel_wdt, 0);
      else        chk(sel_wdt == pri_fail, "R5", "sel vs pri_fail", sel_wdt, pri_fail);
      if (!wdt_maybe) chk(wdt_fail == 1'b0, "R7", "wdt_fail early", wdt_fail, 0);
      if (wdt_must)   chk(wdt_fail == 1'b1, "R7", "wdt_fail late", wdt_fail, 1);
      if (prev_pf)  chk(pri_fail == 1'b1, "R10", "pri_fail cleared", pri_fail, 1);
      if (prev_sel) chk(sel_wdt == 1'b1, "R10", "sel cleared", sel_wdt, 1);
      if (prev_wf)  chk(wdt_fail == 1'b1, "R10", "wdt_fail cleared", wdt_fail, 1);
      if (pri_exc && !prev_pe) begin
        pri_pulses++;
        chk(pri_fail == 1'b1, "R4", "pri_exc without flag", pri_fail, 1);
      end
      if (wdt_exc && !prev_we) begin
        wdt_pulses++;
        chk(wdt_fail == 1'b1, "R8", "wdt_exc without flag", wdt_fail, 1);
      end
      prev_pf = pri_fail; prev_sel = sel_wdt; prev_wf = wdt_fail;
      prev_pe = pri_exc;  prev_we = wdt_exc;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic pe, input logic we, input logic ip, input string req);
    @(negedge clk);
    model_on = 0;
    pri_run = 1; wdt_run = 1;
    rst_n = 0;
    pri_en = pe; wdt_en = we; is_pri = ip;
    cycles(20);
    chk({sel_wdt, pri_fail, pri_exc, wdt_fail, wdt_exc} == 5'b0, "R1", "outputs in reset",
        {sel_wdt, pri_fail, pri_exc, wdt_fail, wdt_exc}, 0);
    pri_stop = 0; wdt_stop = 0;
    pri_maybe = 0; pri_must = 0; wdt_maybe = 0; wdt_must = 0;
    pri_pulses = 0; wdt_pulses = 0;
    prev_pf = 0; prev_sel = 0; prev_wf = 0; prev_pe = 0; prev_we = 0;
    scen_req = req;
    rst_n = 1;
    @(negedge clk);
    chk({sel_wdt, pri_fail, pri_exc, wdt_fail, wdt_exc} == 5'b0, "R1", "outputs after reset",
        {sel_wdt, pri_fail, pri_exc, wdt_fail, wdt_exc}, 0);
    model_on = 1;
  endtask

  task automatic end_scen(input int exp_pp, input int exp_wp);
    cycles(2);
    chk(pri_pulses == exp_pp, "R4", "pri_exc pulse count", pri_pulses, exp_pp);
    chk(wdt_pulses == exp_wp, "R8", "wdt_exc pulse count", wdt_pulses, exp_wp);
  endtask

  initial begin
    fork
      begin
        // R2: both clocks alive, no false failure
        do_reset(1, 1, 0, "R2");
        cycles(3000);
        end_scen(0, 0);

        // R3, R4, R5, R10: primary stops, switchover, then primary restarts
        do_reset(1, 1, 0, "R3");
        pri_run = 0;
        cycles((PL + 10) * WR);
        end_scen(1, 0);
        chk(sel_wdt == 1'b1, "R5", "switchover set", sel_wdt, 1);
        pri_run = 1;
        cycles(400);
        chk(pri_fail == 1'b1 && sel_wdt == 1'b1, "R10", "flags after primary restart",
            {pri_fail, sel_wdt}, 3);
        end_scen(1, 0);

        // R6: detection disabled
        do_reset(0, 1, 0, "R6");
        pri_run = 0;
        cycles((PL + 30) * WR);
        chk(pri_fail == 1'b0 && sel_wdt == 1'b0, "R6", "disabled primary check",
            {pri_fail, sel_wdt}, 0);
        end_scen(0, 0);

        // R5: watchdog already the primary source, no switchover
        do_reset(1, 0, 1, "R3");
        pri_run = 0;
        cycles((PL + 10) * WR);
        chk(pri_fail == 1'b1, "R3", "flag with wdt as primary", pri_fail, 1);
        chk(sel_wdt == 1'b0, "R5", "no override with wdt as primary", sel_wdt, 0);
        end_scen(1, 0);

        // R7, R8: watchdog stops, exception enabled
        do_reset(1, 1, 0, "R7");
        wdt_run = 0;
        cycles(WL + 100);
        chk(wdt_fail == 1'b1, "R7", "wdt failure flagged", wdt_fail, 1);
        chk(sel_wdt == 1'b0, "R8", "no switchover on wdt failure", sel_wdt, 0);
        end_scen(0, 1);

        // R8: watchdog stops, exception disabled
        do_reset(1, 0, 0, "R7");
        wdt_run = 0;
        cycles(WL + 100);
        chk(wdt_fail == 1'b1, "R8", "flag without exception", wdt_fail, 1);
        end_scen(0, 0);

        // R9: watchdog fails, recovers, then primary stops
        do_reset(1, 1, 0, "R9");
        wdt_run = 0;
        cycles(WL + 100);
        wdt_run = 1;
        cycles(40 * WR);
        pri_run = 0;
        cycles((PL + 30) * WR);
        chk(pri_fail == 1'b0 && sel_wdt == 1'b0, "R9", "primary check blocked",
            {pri_fail, sel_wdt}, 0);
        end_scen(0, 1);
        pri_run = 1;
        model_on = 0;
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule